// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause 22 management frames on a two-wire MDIO bus. A CPU reaches it through a flat 32-bit register port with single-cycle writes and combinational reads. It divides the system clock down to MDC. It drives the shared data pin through separate output and output-enable signals and reads it back through a two-flop synchronised input. Launches come from register writes, not from an explicit go bit. Storing a 16-bit value in the write-data register starts a write frame. A 0-to-1 change of the read bit in the command register starts a read frame. Software polls the indication register until the frame ends, then picks up read data from the read-data register.

The frame sequencer is a five-state machine. IDLE leaves the pin released with MDC held low. On a launch (IDLE→PREAMBLE) the target address is captured. PREAMBLE sends 32 ones, and its 32nd MDC fall moves it to HEADER. HEADER sends the 14-bit start/opcode/PHY/register field, and its 14th fall moves it to TURNAROUND. TURNAROUND takes two bits, and its 2nd fall moves it to DATA. DATA carries 16 bits, and its 16th fall returns it to IDLE. A management reset written to the configuration register sends any state straight back to IDLE.

Register map (byte offsets): configuration 0x00, command 0x04, address 0x08, write data 0x0C, read data 0x10, indication 0x14.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the configuration register reads 7 in bits 2:0, the indication, read-data, write-data and address registers read 0, MDC is low and the pin is not driven.
- R2: Writing the write-data register (0x0C) while not busy sends one frame, MSB first: 32 ones, 01, opcode 01, the 5-bit PHY address, the 5-bit register number, 10, then the 16 written bits, with the pin driven for all 64 bits.
- R3: A write of 1 to command bit 0 (0x04) while not busy, when that bit held 0, sends 32 ones, 01, opcode 10, PHY address and register number, and releases the pin for the 2 turnaround bits and the 16 data bits. Writing 1 while the bit already holds 1 launches nothing.
- R4: During a read, the pin is sampled on the 16 MDC rising edges of the data phase, MSB first. Bits 15:0 of the read-data register (0x10) then hold that value.
- R5: Indication bit 0 (busy) reads 1 from the cycle after a launch until the frame ends.
- R6: Indication bit 2 (not-valid) is set by a read launch and cleared when the read-data register is updated. It is never set while busy is clear.
- R7: MDC has a period of 8×(cfg[2:0]+1) system clocks with equal high and low times. Each frame has exactly 64 rising edges. The pin and its enable change only in the cycle MDC falls. MDC is low and the pin released when idle.
- R8: The address register holds the PHY address in bits 12:8 and the register number in bits 4:0. It is captured at launch, so later writes do not alter the frame in progress.
- R9: Writes to the write-data and command registers while busy are ignored. Neither stored value changes, and no further frame follows.
- R10: Writing configuration bit 31 aborts any frame. From the next cycle busy and not-valid read 0, MDC is low and the pin is released. Bit 31 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Pin output value |
| mdio_oe | output | 1 | Pin output enable |
| mdio_i | input | 1 | Pin input value (asynchronous) |

## Verification
The properties assume that each register access lasts one cycle and that the PHY changes the pin only after MDC falls, so that the value is settled through the synchroniser before the next rise. The bench's PHY model updates its drive on the MDC falling edge. It holds the bus low only in the second turnaround bit and the data phase of a read, and it never touches the configuration divider while a frame is running except through the abort path.

// File: rtl/mdio_mm_pkg.sv
package mdio_mm_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_CFG = 5'h00;
    localparam logic [REG_AW-1:0] OFS_CMD = 5'h04;
    localparam logic [REG_AW-1:0] OFS_ADR = 5'h08;
    localparam logic [REG_AW-1:0] OFS_CTL = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_STA = 5'h10;
    localparam logic [REG_AW-1:0] OFS_IND = 5'h14;

    localparam int PRE_LEN = 32;
    localparam int HDR_LEN = 14;
    localparam int TA_LEN  = 2;
    localparam int DAT_LEN = 16;
    localparam int PHY_W   = 5;
    localparam int RNUM_W  = 5;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_PRE,
        FR_HDR,
        FR_TA,
        FR_DATA
    } frame_state_t;

    typedef struct packed {
        logic               rd;
        logic [PHY_W-1:0]   phy;
        logic [RNUM_W-1:0]  regn;
        logic [DAT_LEN-1:0] wdata;
    } mdio_req_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W    = 3,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    localparam int MAX_HALF = PRESCALE * (2 ** DIV_W);
    localparam int CNT_W    = $clog2(MAX_HALF);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;
    logic             mdc_q;
    logic             wrap;

    // half period in system clocks is PRESCALE*(div+1)
    assign half_m1 = CNT_W'(PRESCALE * (int'(div) + 1) - 1);
    assign wrap    = (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc       = mdc_q;
    assign rise_tick = run && wrap && !mdc_q;
    assign fall_tick = run && wrap && mdc_q;

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_mm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  mdio_req_t          req,
    input  logic               abort,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               sdi,
    output logic               busy,
    output logic               rd_done,
    output logic [DAT_LEN-1:0] rd_data,
    output logic               sdo,
    output logic               sdo_en
);
    localparam int CNT_W = $clog2(PRE_LEN);

    frame_state_t       state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [HDR_LEN-1:0] hdr_q;
    logic [DAT_LEN-1:0] dat_q;
    logic               rd_q;
    logic               last_bit;
    logic               step;

    // last bit of the current phase
    always_comb begin
        unique case (state_q)
            FR_IDLE: last_bit = 1'b0;
            FR_PRE:  last_bit = (cnt_q == CNT_W'(PRE_LEN - 1));
            FR_HDR:  last_bit = (cnt_q == CNT_W'(HDR_LEN - 1));
            FR_TA:   last_bit = (cnt_q == CNT_W'(TA_LEN - 1));
            FR_DATA: last_bit = (cnt_q == CNT_W'(DAT_LEN - 1));
            default: last_bit = 1'b0;
        endcase
    end

    assign step = fall_tick && last_bit;

    // next state
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = FR_IDLE;
        end else begin
            unique case (state_q)
                FR_IDLE: if (start) state_d = FR_PRE;
                FR_PRE:  if (step)  state_d = FR_HDR;
                FR_HDR:  if (step)  state_d = FR_TA;
                FR_TA:   if (step)  state_d = FR_DATA;
                FR_DATA: if (step)  state_d = FR_IDLE;
                default:            state_d = FR_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    // bit counter and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hdr_q <= '0;
            dat_q <= '0;
            rd_q  <= 1'b0;
        end else if (abort) begin
            cnt_q <= '0;
        end else if (state_q == FR_IDLE) begin
            if (start) begin
                cnt_q <= '0;
                hdr_q <= {2'b01, (req.rd ? 2'b10 : 2'b01), req.phy, req.regn};
                dat_q <= req.wdata;
                rd_q  <= req.rd;
            end
        end else if (fall_tick) begin
            cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
            if (state_q == FR_HDR)
                hdr_q <= {hdr_q[HDR_LEN-2:0], 1'b0};
            if (state_q == FR_DATA && !rd_q)
                dat_q <= {dat_q[DAT_LEN-2:0], 1'b0};
        end else if (rise_tick && state_q == FR_DATA && rd_q) begin
            dat_q <= {dat_q[DAT_LEN-2:0], sdi};
        end
    end

    assign busy    = (state_q != FR_IDLE);
    assign rd_done = (state_q == FR_DATA) && step && rd_q && !abort;
    assign rd_data = dat_q;

    // pin outputs
    always_comb begin
        sdo    = 1'b1;
        sdo_en = 1'b0;
        unique case (state_q)
            FR_IDLE: begin
                sdo    = 1'b1;
                sdo_en = 1'b0;
            end
            FR_PRE: begin
                sdo    = 1'b1;
                sdo_en = 1'b1;
            end
            FR_HDR: begin
                sdo    = hdr_q[HDR_LEN-1];
                sdo_en = 1'b1;
            end
            FR_TA: begin
                sdo    = rd_q ? 1'b1 : (cnt_q == '0);
                sdo_en = !rd_q;
            end
            FR_DATA: begin
                sdo    = rd_q ? 1'b1 : dat_q[DAT_LEN-1];
                sdo_en = !rd_q;
            end
            default: begin
                sdo    = 1'b1;
                sdo_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_mm_pkg::*;
#(
    parameter int               DIV_W   = 3,
    parameter logic [DIV_W-1:0] DIV_RST = 3'd7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               busy,
    input  logic               rd_done,
    input  logic [DAT_LEN-1:0] rd_data,
    output logic               start,
    output mdio_req_t          req,
    output logic               abort,
    output logic [DIV_W-1:0]   div,
    output logic               notvalid,
    output logic [DAT_LEN-1:0] ctrl_q
);
    logic               wr;
    logic               wr_cfg, wr_cmd, wr_adr, wr_ctl;
    logic               launch_rd, launch_wr;
    logic [DIV_W-1:0]   div_q;
    logic               cmd_q;
    logic [PHY_W-1:0]   phy_q;
    logic [RNUM_W-1:0]  rnum_q;
    logic [DAT_LEN-1:0] stat_q;
    logic               nv_q;

    assign wr     = bus_en && bus_we;
    assign wr_cfg = wr && (bus_addr == OFS_CFG);
    assign wr_cmd = wr && (bus_addr == OFS_CMD);
    assign wr_adr = wr && (bus_addr == OFS_ADR);
    assign wr_ctl = wr && (bus_addr == OFS_CTL);

    assign abort     = wr_cfg && bus_wdata[31];
    assign launch_wr = wr_ctl && !busy;
    assign launch_rd = wr_cmd && !busy && bus_wdata[0] && !cmd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= DIV_RST;
            cmd_q  <= 1'b0;
            phy_q  <= '0;
            rnum_q <= '0;
            ctrl_q <= '0;
            stat_q <= '0;
            nv_q   <= 1'b0;
        end else begin
            if (wr_cfg)
                div_q <= bus_wdata[DIV_W-1:0];
            if (wr_cmd && !busy)
                cmd_q <= bus_wdata[0];
            if (wr_adr) begin
                phy_q  <= bus_wdata[8 +: PHY_W];
                rnum_q <= bus_wdata[0 +: RNUM_W];
            end
            if (launch_wr)
                ctrl_q <= bus_wdata[DAT_LEN-1:0];
            if (rd_done)
                stat_q <= rd_data;
            if (abort)
                nv_q <= 1'b0;
            else if (launch_rd)
                nv_q <= 1'b1;
            else if (rd_done)
                nv_q <= 1'b0;
        end
    end

    assign start     = launch_rd || launch_wr;
    assign req.rd    = launch_rd;
    assign req.phy   = phy_q;
    assign req.regn  = rnum_q;
    assign req.wdata = bus_wdata[DAT_LEN-1:0];
    assign div       = div_q;
    assign notvalid  = nv_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CFG: bus_rdata[DIV_W-1:0]   = div_q;
            OFS_CMD: bus_rdata[0]           = cmd_q;
            OFS_ADR: begin
                bus_rdata[8 +: PHY_W]  = phy_q;
                bus_rdata[0 +: RNUM_W] = rnum_q;
            end
            OFS_CTL: bus_rdata[DAT_LEN-1:0] = ctrl_q;
            OFS_STA: bus_rdata[DAT_LEN-1:0] = stat_q;
            OFS_IND: begin
                bus_rdata[0] = busy;
                bus_rdata[2] = nv_q;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mm_pkg::*;
#(
    parameter int               DIV_W    = 3,
    parameter int               PRESCALE = 4,
    parameter logic [DIV_W-1:0] DIV_RST  = 3'd7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic               busy;
    logic               notvalid;
    logic               abort;
    logic               start;
    mdio_req_t          req;
    logic [DIV_W-1:0]   div;
    logic [DAT_LEN-1:0] ctrl_q;
    logic               rd_done;
    logic [DAT_LEN-1:0] rd_data;
    logic               rise_tick, fall_tick;
    logic [1:0]         sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], mdio_i};
    end

    mdio_regs #(
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .rd_done   (rd_done),
        .rd_data   (rd_data),
        .start     (start),
        .req       (req),
        .abort     (abort),
        .div       (div),
        .notvalid  (notvalid),
        .ctrl_q    (ctrl_q)
    );

    mdio_clkgen #(
        .DIV_W    (DIV_W),
        .PRESCALE (PRESCALE)
    ) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy && !abort),
        .div       (div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req       (req),
        .abort     (abort),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .sdi       (sync_q[1]),
        .busy      (busy),
        .rd_done   (rd_done),
        .rd_data   (rd_data),
        .sdo       (mdio_o),
        .sdo_en    (mdio_oe)
    );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk
    import mdio_mm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_we,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        notvalid,
    input logic [15:0] ctrl_q
);
    logic wr_ctl, wr_abort;
    assign wr_ctl   = bus_en && bus_we && (bus_addr == OFS_CTL);
    assign wr_abort = bus_en && bus_we && (bus_addr == OFS_CFG) && bus_wdata[31];

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_pin_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && ((mdio_o != $past(mdio_o)) || (mdio_oe != $past(mdio_oe))))
        |-> $fell(mdc));

    p_notvalid_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        notvalid |-> busy);

    p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_abort |=> (!busy && !notvalid && !mdc));

    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_ctl) |=> $stable(ctrl_q));

    p_launch_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_ctl) |=> busy);

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .notvalid  (notvalid),
    .ctrl_q    (ctrl_q)
);

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
    import mdio_mm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    logic        phy_drv = 1'b1;
    logic [15:0] rsp = '0;
    int          fc = 0;
    logic [63:0] cap = '0;
    logic [63:0] oe_cap = '0;
    int          n_tests = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_drv;

    mdio_mgmt_master dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: record master bits on rise, drive read bits after fall
    always @(posedge mdc) begin
        if (fc < 64) begin
            cap[63-fc]    = mdio_oe ? mdio_o : 1'b1;
            oe_cap[63-fc] = mdio_oe;
        end
        fc = fc + 1;
    end

    always @(negedge mdc) begin
        if (fc == 47)                 phy_drv = 1'b0;
        else if (fc >= 48 && fc < 64) phy_drv = rsp[63-fc];
        else                          phy_drv = 1'b1;
    end

    // rd, phy, reg, data (write data or PHY response)
    localparam logic [26:0] VEC [6] = '{
        {1'b0, 5'h01, 5'h00, 16'h1234},
        {1'b1, 5'h1F, 5'h1F, 16'hA5C3},
        {1'b0, 5'h10, 5'h15, 16'hFFFF},
        {1'b1, 5'h00, 5'h02, 16'h8001},
        {1'b0, 5'h0A, 5'h0A, 16'h0000},
        {1'b1, 5'h15, 5'h0E, 16'hFFFF}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bwr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic brd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 4000; i++) begin
            brd(OFS_IND, d);
            if (!d[0]) break;
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R5: actual hung expected finished");
        finish_run();
    end

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                               input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
    endfunction

    initial begin
        logic [31:0] d;
        real t0, t1, t2;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        brd(OFS_CFG, d); chk("R1", "cfg", 64'(d), 64'd7);
        brd(OFS_IND, d); chk("R1", "ind", 64'(d), 64'd0);
        brd(OFS_STA, d); chk("R1", "stat", 64'(d), 64'd0);
        brd(OFS_CTL, d); chk("R1", "ctrl", 64'(d), 64'd0);
        brd(OFS_ADR, d); chk("R1", "addr", 64'(d), 64'd0);
        chk("R1", "mdc/oe idle", {62'd0, mdc, mdio_oe}, 64'd0);

        // R7: MDC period with divider 1
        bwr(OFS_CFG, 32'd1);
        bwr(OFS_CTL, 32'h0000_0F0F);
        @(posedge mdc); t0 = $realtime;
        @(posedge mdc); t1 = $realtime;
        @(negedge mdc); t2 = $realtime;
        chk("R7", "period div1", 64'(int'((t1 - t0) / 5.0)), 64'd16);
        chk("R7", "high div1", 64'(int'((t2 - t1) / 5.0)), 64'd8);
        wait_idle();
        bwr(OFS_CFG, 32'd0);
        chk("R7", "idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);

        // vector table walk: R2 R3 R4 R5 R6 R8
        foreach (VEC[k]) begin
            logic        v_rd;
            logic [4:0]  v_phy, v_reg;
            logic [15:0] v_dat;
            {v_rd, v_phy, v_reg, v_dat} = VEC[k];
            fc = 0;
            rsp = v_dat;
            bwr(OFS_ADR, {19'd0, v_phy, 3'd0, v_reg});
            if (v_rd) begin
                bwr(OFS_CMD, 32'd0);
                bwr(OFS_CMD, 32'd1);
            end else begin
                bwr(OFS_CTL, {16'd0, v_dat});
            end
            brd(OFS_IND, d);
            chk("R5", "busy after launch", 64'(d[0]), 64'd1);
            chk("R6", "notvalid after launch", 64'(d[2]), 64'(v_rd));
            if (v_rd) begin
                @(posedge mdc);
                @(negedge mdc);
                chk("R7", "period div0", 64'(fc), 64'd1);
            end
            wait_idle();
            chk("R7", "rises per frame", 64'(fc), 64'd64);
            chk(v_rd ? "R3" : "R2", "frame bits", cap, exp_frame(v_rd, v_phy, v_reg, v_dat));
            chk(v_rd ? "R3" : "R2", "drive enable", oe_cap,
                v_rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}});
            if (v_rd) begin
                brd(OFS_STA, d); chk("R4", "read data", 64'(d), 64'(v_dat));
                brd(OFS_IND, d); chk("R6", "notvalid clear", 64'(d), 64'd0);
            end else begin
                brd(OFS_CTL, d); chk("R2", "ctrl readback", 64'(d), 64'(v_dat));
            end
        end

        // R8 / R9: writes during a frame
        fc = 0;
        bwr(OFS_ADR, 32'h0000_0304);
        bwr(OFS_CTL, 32'h0000_00FF);
        bwr(OFS_ADR, 32'h0000_1B1B);
        bwr(OFS_CTL, 32'h0000_BEEF);
        bwr(OFS_CMD, 32'd0);
        wait_idle();
        chk("R8", "latched address", cap, exp_frame(1'b0, 5'h03, 5'h04, 16'h00FF));
        brd(OFS_CTL, d); chk("R9", "ctrl ignored", 64'(d), 64'h00FF);
        brd(OFS_CMD, d); chk("R9", "cmd ignored", 64'(d), 64'd1);
        repeat (100) @(posedge clk);
        chk("R9", "no extra frame", 64'(fc), 64'd64);
        brd(OFS_ADR, d); chk("R8", "addr field layout", 64'(d), 64'h1B1B);

        // R3: 1 written over a stored 1 launches nothing
        bwr(OFS_CMD, 32'd1);
        brd(OFS_IND, d); chk("R3", "no relaunch", 64'(d), 64'd0);

        // R10: abort a read
        fc = 0;
        bwr(OFS_CMD, 32'd0);
        bwr(OFS_CMD, 32'd1);
        repeat (100) @(posedge clk);
        bwr(OFS_CFG, 32'h8000_0000);
        brd(OFS_IND, d); chk("R10", "ind after abort", 64'(d), 64'd0);
        chk("R10", "mdc/oe after abort", {62'd0, mdc, mdio_oe}, 64'd0);
        brd(OFS_CFG, d); chk("R10", "bit31 not stored", 64'(d), 64'd0);

        // R4: read after abort
        fc = 0;
        rsp = 16'h5A5A;
        bwr(OFS_ADR, 32'h0000_0201);
        bwr(OFS_CMD, 32'd0);
        bwr(OFS_CMD, 32'd1);
        wait_idle();
        brd(OFS_STA, d); chk("R4", "read after abort", 64'(d), 64'h5A5A);
        chk("R3", "read header after abort", {cap[63:18], 18'd0},
            {exp_frame(1'b1, 5'h02, 5'h01, 16'h0)} & {{46{1'b1}}, 18'd0});

        finish_run();
    end

endmodule